// File: doc/BRIEF.md
# I2S Master Serial Audio Port

This block is the master end of a two-channel I2S link. A fast system clock drives it. From that clock it makes the bit clock and the left/right frame select. It shifts one transmit word out on the data-out pin while it shifts one receive word in from the data-in pin. The block stays silent after reset. Both serial clocks start only when the host hands over the first transmit word. After that they run without a break. If the host falls behind, the block records an error and repeats the last word; the clocks do not stop.

The host side has two streams. The transmit stream is a one-word holding register. `tx_ready` is high while the register is empty, so it can drive a DMA request. The host holds `tx_valid` and `tx_data` until it sees `tx_ready`. A word is taken on a clock where both are high. `tx_ready` stays low until the shifter takes the word at the first bit of the next slot.

The receive stream is also a one-word register. `rx_valid` works as a full flag. It stays high, with `rx_data` held, until a clock where `rx_ready` is high. The serial link does not wait for the host. If a new word completes while the old one is unread, the new word replaces it and the error flag sets.

Two configuration bytes set the timing:
- `cfg_half_div` = divider/2 − 1. It gives the number of system clocks in each bit-clock half period, minus one.
- `cfg_word_edges` = 2·N − 1. It gives the number of bit-clock edges in each N-bit word, minus one.

The values 1 and 63 select the usual setting: 32-bit words at divide-by-4. Both bytes must be held constant while the clocks run.

Top module: `i2s_master_port`

## Requirements
- R1: After reset, `bclk_o` stays 0 and `fsync_o` stays 1 until the first transmit word is accepted. Both clocks then start on their own.
- R2: The `bclk_o` period is 2·(`cfg_half_div`+1) system clocks, with a 50% duty cycle. `cfg_half_div` must be 1 or more, so the smallest divider is 4.
- R3: The word length is N = (`cfg_word_edges`+1)/2, with N from 2 to WORD_MAX. `fsync_o` toggles once every N bit-clock periods.
- R4: `fsync_o` changes only on a rising edge of `bclk_o`. Its first change is 1→0, on the very first rising edge of `bclk_o`. Low marks the left channel and high marks the right.
- R5: `sdata_o` changes only on rising edges of `bclk_o`. Each word goes out MSB first (bit N−1 first). The MSB appears one bit clock after the `fsync_o` change that opens its slot. No extra framing bits are added.
- R6: `sdata_i` passes through a two-flop synchronizer. It is sampled at the falling edges of `bclk_o`, with the synchronizer delay made up. A loop from `sdata_o` back to `sdata_i` with up to 1.5 system clocks of delay returns every word unchanged.
- R7: `tx_ready` is high exactly while the holding register is empty. It goes low on the clock after a word is accepted. It returns high when the shifter takes the word at the MSB of the next slot.
- R8: `rx_valid` rises with the received word on the clock after the last bit is captured. `rx_data` is held while `rx_valid` is high and `rx_ready` is low. `rx_valid` drops on the clock after `rx_valid`·`rx_ready`.
- R9: Underrun: if the holding register is empty when the shifter needs a word, `err_flag` sets. The previous word is sent again and `bclk_o` keeps running.
- R10: Overflow: if a word completes while `rx_valid` is high and `rx_ready` is low, `err_flag` sets and `rx_data` takes the newer word.
- R11: `err_flag` is sticky. A one-clock pulse on `err_clr` clears it.
- R12: After reset the outputs are: `bclk_o`=0, `fsync_o`=1, `sdata_o`=0, `tx_ready`=1, `rx_valid`=0 and `err_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_div | input | 8 | Bit-clock half period in system clocks, minus one |
| cfg_word_edges | input | 8 | Bit-clock edges per word, minus one (2·N − 1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | WORD_MAX | Transmit word, right-aligned in N bits |
| rx_valid | output | 1 | Receive register full |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | WORD_MAX | Received word, right-aligned, upper bits zero |
| err_flag | output | 1 | Sticky underrun/overflow flag |
| err_clr | input | 1 | Clear strobe for `err_flag` |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame select (0 = left, 1 = right) |
| sdata_o | output | 1 | Serial data out |
| sdata_i | input | 1 | Serial data in |

## Verification
- **Half-period counter.** A wrong value here shows up in the spacing of `bclk_o` edges within one bit period.
- **Edge index.** A slip here moves the `fsync_o` change off the slot boundary. It also moves the load point, so the recovered serial word is rotated within the first word.
- **Sample pipeline.** If the receive pipeline is not aligned with the synchronizer, the looped-back word comes back shifted or wrong. Sweeping the loop delay over 0, 1 and 1.5 clocks at the smallest divider shows this on the first received word.
- **Buffer flags.** A wrong full or empty flag shows up as a wrong `tx_ready` or `rx_valid` on the next clock. It can also show up as a wrong `err_flag` within one word slot.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  // width of both configuration bytes and of the edge index
  localparam int CFG_W = 8;

  // falling-edge sample request travelling alongside the synchronizer
  typedef struct packed {
    logic             fall;
    logic [CFG_W-1:0] idx;
  } smp_req_t;
endpackage

// File: rtl/i2s_sclk_gen.sv
module i2s_sclk_gen
  import i2s_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_half,
  input  logic [CFG_W-1:0] cfg_edges,
  output logic             bclk,
  output logic             fsync,
  output logic             running,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [CFG_W-1:0] edge_idx
);
  logic [CFG_W-1:0] half_q;
  logic [CFG_W-1:0] edge_q;
  logic             tick;

  // one bit-clock edge is due at the end of this cycle
  assign tick     = running && (half_q >= cfg_half);
  assign rise_evt = tick && !bclk;
  assign fall_evt = tick && bclk;
  assign edge_idx = edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      half_q  <= '0;
      edge_q  <= '0;
      bclk    <= 1'b0;
      fsync   <= 1'b1;
    end else begin
      if (start) running <= 1'b1;
      if (running) begin
        if (tick) begin
          half_q <= '0;
          bclk   <= ~bclk;
          edge_q <= (edge_q >= cfg_edges) ? '0 : edge_q + 1'b1;
          // slot boundary: rising edge with index 0, one bit ahead of the MSB
          if (!bclk && edge_q == '0) fsync <= ~fsync;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end
    end
  end

  // R1: the serial clocks stay idle until the first transmit word arrives
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (bclk == 1'b0 && fsync == 1'b1));

  // R4: the frame select moves only together with a rising bit-clock edge
  p_fsync_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $rose(bclk));
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
  import i2s_port_pkg::*;
#(
  parameter int WORD_MAX = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_evt,
  input  logic [CFG_W-1:0]    edge_idx,
  input  logic [CFG_W-1:0]    nbits,
  input  logic                tx_valid,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                tx_ready,
  output logic                accept,
  output logic                underrun,
  output logic                sdata
);
  localparam logic [CFG_W:0]       WMAX     = (CFG_W+1)'(WORD_MAX);
  localparam logic [CFG_W-1:0]     LOAD_IDX = CFG_W'(2);

  logic                full_q;
  logic [WORD_MAX-1:0] hold_q;
  logic [WORD_MAX-1:0] last_q;
  logic [WORD_MAX-1:0] shift_q;
  logic [WORD_MAX-1:0] word_sel;
  logic [WORD_MAX-1:0] aligned;
  logic [CFG_W:0]      shamt;
  logic                load;

  assign tx_ready = !full_q;
  assign accept   = tx_valid && !full_q;
  assign load     = rise_evt && (edge_idx == LOAD_IDX);
  assign underrun = load && !full_q;

  // on underrun the previously sent word goes out again
  assign word_sel = full_q ? hold_q : last_q;
  assign shamt    = WMAX - {1'b0, nbits};
  assign aligned  = word_sel << shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      hold_q  <= '0;
      last_q  <= '0;
      shift_q <= '0;
      sdata   <= 1'b0;
    end else begin
      if (load && full_q) begin
        full_q <= 1'b0;
        last_q <= hold_q;
      end
      if (accept) begin
        full_q <= 1'b1;
        hold_q <= tx_data;
      end
      if (load) begin
        sdata   <= aligned[WORD_MAX-1];
        shift_q <= aligned << 1;
      end else if (rise_evt) begin
        sdata   <= shift_q[WORD_MAX-1];
        shift_q <= shift_q << 1;
      end
    end
  end

  // R7: a waiting word is neither lost nor altered before the shifter takes it
  p_hold_until_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
  import i2s_port_pkg::*;
#(
  parameter int WORD_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_evt,
  input  logic [CFG_W-1:0]    edge_idx,
  input  logic [CFG_W-1:0]    nbits,
  input  logic                sdata,
  input  logic                rx_ready,
  output logic                rx_valid,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                overflow
);
  localparam logic [CFG_W-1:0] FIRST_IDX = CFG_W'(3);
  localparam logic [CFG_W-1:0] LAST_IDX  = CFG_W'(1);

  logic     sync_q [SYNC_STAGES];
  smp_req_t pipe_q [SYNC_STAGES];
  smp_req_t smp;
  logic     bit_in;

  // synchronizer and a matching delay line for the sample request
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sync_q[0] <= 1'b0;
          pipe_q[0] <= '0;
        end else begin
          sync_q[0] <= sdata;
          pipe_q[0] <= '{fall: fall_evt, idx: edge_idx};
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sync_q[g] <= 1'b0;
          pipe_q[g] <= '0;
        end else begin
          sync_q[g] <= sync_q[g-1];
          pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  end

  assign smp    = pipe_q[SYNC_STAGES-1];
  assign bit_in = sync_q[SYNC_STAGES-1];

  logic [WORD_MAX-2:0] shift_q;
  logic [WORD_MAX-1:0] next_w;
  logic [WORD_MAX-1:0] mask;
  logic                primed_q;
  logic                complete;
  logic                take;

  assign next_w   = {shift_q, bit_in};
  assign mask     = ~({WORD_MAX{1'b1}} << nbits);
  assign complete = smp.fall && (smp.idx == LAST_IDX) && primed_q;
  assign take     = rx_valid && rx_ready;
  assign overflow = complete && rx_valid && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      primed_q <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (smp.fall) shift_q <= next_w[WORD_MAX-2:0];
      if (smp.fall && smp.idx == FIRST_IDX) primed_q <= 1'b1;
      if (complete) begin
        rx_valid <= 1'b1;
        rx_data  <= next_w & mask;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R8: an unread word stays put unless a newer one completes
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !complete) |=> (rx_valid && $stable(rx_data)));

  // R10: an overflowing word leaves the register full
  p_overflow_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> rx_valid);
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2s_port_pkg::*;
#(
  parameter int WORD_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_half_div,
  input  logic [CFG_W-1:0]    cfg_word_edges,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                err_flag,
  input  logic                err_clr,
  output logic                bclk_o,
  output logic                fsync_o,
  output logic                sdata_o,
  input  logic                sdata_i
);
  logic             running;
  logic             rise_evt;
  logic             fall_evt;
  logic [CFG_W-1:0] edge_idx;
  logic [CFG_W-1:0] nbits;
  logic             accept;
  logic             underrun;
  logic             overflow;

  assign nbits = CFG_W'(({1'b0, cfg_word_edges} + (CFG_W+1)'(1)) >> 1);

  i2s_sclk_gen u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .cfg_half (cfg_half_div),
    .cfg_edges(cfg_word_edges),
    .bclk     (bclk_o),
    .fsync    (fsync_o),
    .running  (running),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .edge_idx (edge_idx)
  );

  i2s_tx_lane #(.WORD_MAX(WORD_MAX)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .edge_idx (edge_idx),
    .nbits    (nbits),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .accept   (accept),
    .underrun (underrun),
    .sdata    (sdata_o)
  );

  i2s_rx_lane #(.WORD_MAX(WORD_MAX), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .edge_idx (edge_idx),
    .nbits    (nbits),
    .sdata    (sdata_i),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .overflow (overflow)
  );

  // sticky error; a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                     err_flag <= 1'b0;
    else if (underrun || overflow)  err_flag <= 1'b1;
    else if (err_clr)               err_flag <= 1'b0;
  end

  // R2: the divider never runs below divide-by-4
  p_div_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cfg_half_div != '0));

  // R5: serial data moves only with a rising bit-clock edge
  p_sdata_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $rose(bclk_o));

  // R11: the error flag holds until cleared
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

// File: tb/sim_i2s_master_port.sv
`timescale 1ns/1ps
module sim_i2s_master_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half_div = 8'd1;
  logic [7:0]  cfg_word_edges = 8'd63;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [31:0] rx_data;
  logic        err_flag;
  logic        err_clr = 1'b0;
  logic        bclk_o, fsync_o, sdata_o, sdata_i;

  always #4 clk = ~clk;

  // loopback with selectable delay: 0, 1 or 1.5 system clocks
  int   lb_sel = 0;
  logic lb1 = 1'b0, lb15 = 1'b0;
  always @(posedge clk) lb1 <= sdata_o;
  always @(negedge clk) lb15 <= lb1;
  assign sdata_i = (lb_sel == 0) ? sdata_o : (lb_sel == 1) ? lb1 : lb15;

  i2s_master_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_word_edges(cfg_word_edges),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .err_flag(err_flag), .err_clr(err_clr),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o), .sdata_i(sdata_i)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // serial-side monitor, sampled away from the active edge
  logic        mon_clr = 1'b1;
  int          cur_n = 32;
  int          cyc = 0, rises = 0, last_rise = 0, per_min = 0, per_max = 0;
  int          ws_good = 0, ws_bad = 0, sd_bad = 0, bidx = 0;
  logic        prev_sck = 1'b0, prev_ws = 1'b1, prev_sd = 1'b0, is_rise;
  logic [31:0] ser [8];
  int          rx_cnt = 0;
  logic [31:0] rxw [8];
  logic        err_at1 = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      rises = 0; per_min = 1 << 30; per_max = 0; ws_good = 0; ws_bad = 0; sd_bad = 0;
      prev_sck = bclk_o; prev_ws = fsync_o; prev_sd = sdata_o; rx_cnt = 0; err_at1 = 1'b0;
      for (int k = 0; k < 8; k++) begin ser[k] = '0; rxw[k] = '0; end
    end else begin
      is_rise = bclk_o && !prev_sck;
      if (is_rise) begin
        rises++;
        if (rises > 1) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (rises >= 2) begin
          bidx = rises - 2;
          if (bidx / cur_n < 8) ser[bidx / cur_n][cur_n - 1 - (bidx % cur_n)] = sdata_o;
        end
      end
      if (fsync_o != prev_ws) begin
        if (is_rise && ((rises - 1) % cur_n == 0) && (rises != 1 || fsync_o == 1'b0)) ws_good++;
        else ws_bad++;
      end
      if (sdata_o != prev_sd && !is_rise) sd_bad++;
      if (rx_valid && rx_ready) begin
        if (rx_cnt == 1) err_at1 = err_flag;
        if (rx_cnt < 8) rxw[rx_cnt] = rx_data;
        rx_cnt++;
      end
      prev_sck = bclk_o; prev_ws = fsync_o; prev_sd = sdata_o;
    end
  end

  function automatic logic [31:0] pat(input int k, input int n);
    logic [31:0] m = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    if (k == 1) return m;
    return ((32'h9E37_79B9 * (k + 3)) ^ 32'hA5C3_1E69 ^ (32'h1 << (n - 1))) & m;
  endfunction

  task automatic start_cfg(input int h, input int n, input int sel, input bit rdy);
    rst_n = 1'b0; mon_clr = 1'b1; tx_valid = 1'b0; err_clr = 1'b0; rx_ready = rdy;
    cfg_half_div = 8'(h); cfg_word_edges = 8'(2 * n - 1); cur_n = n; lb_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    // R12 reset state {bclk,fsync,sdata,tx_ready,rx_valid,err}
    chk({bclk_o, fsync_o, sdata_o, tx_ready, rx_valid, err_flag} == 6'b010100, "R12 reset state",
        32'({bclk_o, fsync_o, sdata_o, tx_ready, rx_valid, err_flag}), 32'b010100);
    repeat (30) @(negedge clk);
    chk(bclk_o == 1'b0 && fsync_o == 1'b1 && rises == 0, "R1 hold-off", 32'({bclk_o, fsync_o}), 32'b01);
  endtask

  task automatic send(input logic [31:0] w);
    tx_data = w;
    do @(negedge clk); while (!tx_ready);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R7 ready low while full", 32'(tx_ready), 32'd0);
  endtask

  task automatic run_cfg(input int h, input int n, input int sel);
    start_cfg(h, n, sel, 1'b1);
    for (int k = 0; k < 3; k++) send(pat(k, n));
    while (rx_cnt < 3) @(negedge clk);
    while (rises < 2 + 4 * n) @(negedge clk);
    chk(per_min == 2 * (h + 1) && per_max == 2 * (h + 1), "R2 bclk period",
        32'(per_max), 32'(2 * (h + 1)));
    chk(per_min == per_max, "R2 bclk period steady", 32'(per_min), 32'(per_max));
    chk(ws_bad == 0, "R4 fsync edge placement", 32'(ws_bad), 32'd0);
    chk(ws_good >= 5, "R3 fsync toggles per word", 32'(ws_good), 32'd5);
    chk(sd_bad == 0, "R5 sdata only on rising edge", 32'(sd_bad), 32'd0);
    for (int k = 0; k < 3; k++) begin
      chk(ser[k] == pat(k, n), "R5 serial word MSB first", ser[k], pat(k, n));
      chk(rxw[k] == pat(k, n), "R6 loopback word", rxw[k], pat(k, n));
    end
    chk(err_at1 == 1'b0, "R9 no error while fed", 32'(err_at1), 32'd0);
    chk(err_flag == 1'b1, "R9 underrun flag", 32'(err_flag), 32'd1);
    chk(ser[3] == pat(2, n), "R9 last word repeated", ser[3], pat(2, n));
    // clear right after a rising edge, well before the next load point
    while (bclk_o) @(negedge clk);
    while (!bclk_o) @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_flag == 1'b0, "R11 clear strobe", 32'(err_flag), 32'd0);
  endtask

  task automatic run_overflow();
    start_cfg(1, 8, 1, 1'b0);
    for (int k = 0; k < 3; k++) send(pat(k, 8));
    while (!rx_valid) @(negedge clk);
    chk(rx_data == pat(0, 8), "R8 first word presented", rx_data, pat(0, 8));
    repeat (5) @(negedge clk);
    chk(rx_valid && rx_data == pat(0, 8), "R8 word held while not ready", rx_data, pat(0, 8));
    chk(err_flag == 1'b0, "R10 no error before overflow", 32'(err_flag), 32'd0);
    while (!err_flag) @(negedge clk);
    chk(rx_valid && rx_data == pat(1, 8), "R10 newer word replaces", rx_data, pat(1, 8));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(!rx_valid, "R8 valid drops after take", 32'(rx_valid), 32'd0);
    chk(err_flag == 1'b1, "R11 flag sticky", 32'(err_flag), 32'd1);
  endtask

  task automatic run_all();
    int hs[3] = '{1, 2, 3};
    int ns[4] = '{2, 5, 8, 32};
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 3; c++)
          run_cfg(hs[a], ns[b], c);
    run_overflow();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule